// File: doc/BRIEF.md
# Transmit Descriptor Ring Walker

This block is the front end of a transmit DMA. It follows a circular chain of four-word descriptors held in memory. Each descriptor is, in address order: a control word, a buffer pointer, a length/status word and a link pointer to the next descriptor. Software writes the ring base, sets up descriptors with their ownership bit set, and then issues a start demand. The walker then fetches descriptors one after another. For each owned descriptor it passes the buffer pointer, the length and the per-frame options to a transmit engine. It waits for that engine to finish and writes the result back into the descriptor. After that it moves to the next descriptor.

The walk ends when the walker fetches a descriptor that software still owns, or when a memory access fails. Either case sets a status flag. Software can poll the address of the descriptor being worked on to follow progress. An interrupt line combines the status flags with an enable mask. Memory traffic uses a single-word request/grant port: read data and the error flag are valid in the cycle in which the grant is high.

Top module: `tx_ring_walker`

## Requirements
- R1: After reset the walker is idle. `mem_req`, `tx_req` and `irq` are low, and the status register (offset 0xB0) and the current-descriptor register (offset 0xCC) both read zero.
- R2: A write to the ring base register (offset 0x88) while the walker is idle loads the current-descriptor address. Offset 0x88 reads back the base and offset 0xCC reads back the new current address.
- R3: A start demand is a write to offset 0xA0 with data bit 0 set. It causes four word reads at the current address plus 0, 4, 8 and 12, in that order. `mem_addr` holds steady while a request waits for its grant.
- R4: For a descriptor whose control word has bit 31 set, `tx_req` rises with the buffer pointer, padding taken from control bit 0 and CRC append taken from control bit 1. The length is bits 15:0 of the length word, capped at 1514. `tx_req` and its data hold until `tx_done`.
- R5: After `tx_done`, the walker writes the length/status word at offset 8. That word keeps the length in bits 15:0, has bit 19 equal to `tx_ok`, and has all other bits zero. The walker then writes the control word back with bit 31 cleared. Only after that does it load the link pointer as the current address and fetch again.
- R6: A fetched control word with bit 31 clear stops the walk. It sets status bit 23, raises no `tx_req`, and leaves the current address on that descriptor.
- R7: A memory access that returns `mem_err` with its grant stops the walk and sets status bit 24. No transfer starts for that descriptor.
- R8: Status bit 18 is set when a descriptor is completed, but only if its control bit 2 was set.
- R9: Writing ones to the status register clears those bits. Zero bits are left as they are.
- R10: `irq` is high exactly when some status bit is set whose matching bit in the enable register (offset 0xAC) is also set.
- R11: A write to offset 0xA0 with data bit 0 clear starts nothing.
- R12: Offset 0xD0 reads the buffer pointer of the most recently fetched descriptor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register byte offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data, combinational from cfg_addr |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Word byte address |
| mem_wdata | output | 32 | Write data |
| mem_gnt | input | 1 | Access accepted this cycle |
| mem_rdata | input | 32 | Read data, valid with grant |
| mem_err | input | 1 | Access failed, valid with grant |
| tx_req | output | 1 | Frame transfer request to transmit engine |
| tx_buf | output | 32 | Frame buffer pointer |
| tx_len | output | 16 | Frame length, capped |
| tx_pad | output | 1 | Pad short frames |
| tx_crc | output | 1 | Append CRC |
| tx_done | input | 1 | Transfer finished, one-cycle pulse |
| tx_ok | input | 1 | Transfer succeeded, valid with tx_done |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds a three-descriptor ring. The first descriptor has an oversized length, so a walker that did not cap it would hand 2000 to the engine rather than 1514. The second descriptor reports failure, so a walker that always wrote success would leave bit 19 set in its length word. The third descriptor is left owned by software, which should stop the walk at that descriptor. A second pass checks that a descriptor without the interrupt option leaves bit 18 clear; a walker that ignored that option would flag every completion. A third pass injects a fetch error on the buffer word. A walker that went on regardless would raise a transfer request with garbage data, or would move the current address past the failing descriptor.

// File: rtl/tx_ring_pkg.sv
// Shared constants and types for the transmit descriptor ring walker.
package tx_ring_pkg;
    // Register byte offsets.
    localparam logic [7:0] OFS_BASE   = 8'h88;
    localparam logic [7:0] OFS_START  = 8'hA0;
    localparam logic [7:0] OFS_IEN    = 8'hAC;
    localparam logic [7:0] OFS_STAT   = 8'hB0;
    localparam logic [7:0] OFS_CUR    = 8'hCC;
    localparam logic [7:0] OFS_BUF    = 8'hD0;

    // Status bit positions.
    localparam int ST_DONE    = 18;
    localparam int ST_UNAVAIL = 23;
    localparam int ST_BUSERR  = 24;

    // Control word bit positions.
    localparam int CW_PAD   = 0;
    localparam int CW_CRC   = 1;
    localparam int CW_IRQ   = 2;
    localparam int CW_OWNER = 31;

    // Length/status word bit position.
    localparam int LS_OK = 19;

    typedef enum logic [2:0] {
        S_IDLE, S_RD_CTL, S_RD_BUF, S_RD_LEN, S_RD_LINK,
        S_XMIT, S_WB_LEN, S_WB_CTL
    } walk_state_t;
endpackage

// File: rtl/tx_ring_regs.sv
// Register file of the ring walker: base, enable mask and status with
// write-one-to-clear, plus the read mux. Assumes events are single-cycle
// pulses; a set from an event wins over a clear in the same cycle.
module tx_ring_regs
    import tx_ring_pkg::*;
#(
    parameter int DW = 32,
    parameter int RW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [RW-1:0] cfg_addr,
    input  logic [DW-1:0] cfg_wdata,
    output logic [DW-1:0] cfg_rdata,
    input  logic          ev_done,
    input  logic          ev_unavail,
    input  logic          ev_berr,
    input  logic [DW-1:0] cur_addr,
    input  logic [DW-1:0] buf_addr,
    output logic          start_pulse,
    output logic          base_load,
    output logic [DW-1:0] base_val,
    output logic          irq
);
    logic [DW-1:0] base_q, ien_q, stat_q, set_v;

    assign start_pulse = cfg_we && (cfg_addr == OFS_START) && cfg_wdata[0];
    assign base_load   = cfg_we && (cfg_addr == OFS_BASE);
    assign base_val    = cfg_wdata;

    // Collect this cycle's event bits.
    always_comb begin
        set_v = '0;
        set_v[ST_DONE]    = ev_done;
        set_v[ST_UNAVAIL] = ev_unavail;
        set_v[ST_BUSERR]  = ev_berr;
    end

    // Hold base, enable and status registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            ien_q  <= '0;
            stat_q <= '0;
        end else begin
            if (base_load) base_q <= cfg_wdata;
            if (cfg_we && cfg_addr == OFS_IEN) ien_q <= cfg_wdata;
            if (cfg_we && cfg_addr == OFS_STAT)
                stat_q <= (stat_q & ~cfg_wdata) | set_v;
            else
                stat_q <= stat_q | set_v;
        end
    end

    // Read mux.
    always_comb begin
        case (cfg_addr)
            OFS_BASE: cfg_rdata = base_q;
            OFS_IEN:  cfg_rdata = ien_q;
            OFS_STAT: cfg_rdata = stat_q;
            OFS_CUR:  cfg_rdata = cur_addr;
            OFS_BUF:  cfg_rdata = buf_addr;
            default:  cfg_rdata = '0;
        endcase
    end

    assign irq = |(stat_q & ien_q);

    AST_EVENT_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        ev_unavail |=> stat_q[ST_UNAVAIL]); // R6
endmodule

// File: rtl/tx_ring_seq.sv
// Descriptor walk sequencer. Fetches the four descriptor words, hands an
// owned frame to the transmit engine, writes back status and the control
// word with ownership cleared, then follows the link. Assumes read data and
// error are valid in the grant cycle and tx_done is a one-cycle pulse.
module tx_ring_seq
    import tx_ring_pkg::*;
#(
    parameter int DW      = 32,
    parameter int LW      = 16,
    parameter int LEN_MAX = 1514
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_pulse,
    input  logic          base_load,
    input  logic [DW-1:0] base_val,
    output logic          mem_req,
    output logic          mem_we,
    output logic [DW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic          mem_gnt,
    input  logic [DW-1:0] mem_rdata,
    input  logic          mem_err,
    output logic          tx_req,
    output logic [DW-1:0] tx_buf,
    output logic [LW-1:0] tx_len,
    output logic          tx_pad,
    output logic          tx_crc,
    input  logic          tx_done,
    input  logic          tx_ok,
    output logic          ev_done,
    output logic          ev_unavail,
    output logic          ev_berr,
    output logic [DW-1:0] cur_addr,
    output logic [DW-1:0] buf_addr
);
    localparam int WB = DW / 8;
    localparam logic [LW-1:0] CAP = LW'(LEN_MAX);

    walk_state_t   state;
    logic [DW-1:0] cur_q, buf_q, ctl_q, len_q, link_q;
    logic          ok_q, acc_ok;

    assign acc_ok = mem_gnt && !mem_err;

    // Walk state and captured descriptor words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= S_IDLE;
            cur_q  <= '0;
            buf_q  <= '0;
            ctl_q  <= '0;
            len_q  <= '0;
            link_q <= '0;
            ok_q   <= 1'b0;
        end else begin
            case (state)
                S_IDLE: begin
                    if (base_load) cur_q <= base_val;
                    if (start_pulse) state <= S_RD_CTL;
                end
                S_RD_CTL: if (mem_gnt) begin
                    if (mem_err || !mem_rdata[CW_OWNER]) state <= S_IDLE;
                    else begin ctl_q <= mem_rdata; state <= S_RD_BUF; end
                end
                S_RD_BUF: if (mem_gnt) begin
                    if (mem_err) state <= S_IDLE;
                    else begin buf_q <= mem_rdata; state <= S_RD_LEN; end
                end
                S_RD_LEN: if (mem_gnt) begin
                    if (mem_err) state <= S_IDLE;
                    else begin len_q <= mem_rdata; state <= S_RD_LINK; end
                end
                S_RD_LINK: if (mem_gnt) begin
                    if (mem_err) state <= S_IDLE;
                    else begin link_q <= mem_rdata; state <= S_XMIT; end
                end
                S_XMIT: if (tx_done) begin
                    ok_q  <= tx_ok;
                    state <= S_WB_LEN;
                end
                S_WB_LEN: if (mem_gnt) state <= mem_err ? S_IDLE : S_WB_CTL;
                S_WB_CTL: if (mem_gnt) begin
                    if (mem_err) state <= S_IDLE;
                    else begin cur_q <= link_q; state <= S_RD_CTL; end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // Memory request address, direction and write data per state.
    always_comb begin
        mem_req   = 1'b1;
        mem_we    = 1'b0;
        mem_wdata = '0;
        mem_addr  = cur_q;
        case (state)
            S_RD_CTL:  mem_addr = cur_q;
            S_RD_BUF:  mem_addr = cur_q + DW'(WB);
            S_RD_LEN:  mem_addr = cur_q + DW'(2 * WB);
            S_RD_LINK: mem_addr = cur_q + DW'(3 * WB);
            S_WB_LEN: begin
                mem_we    = 1'b1;
                mem_addr  = cur_q + DW'(2 * WB);
                mem_wdata = DW'(len_q[LW-1:0]);
                mem_wdata[LS_OK] = ok_q;
            end
            S_WB_CTL: begin
                mem_we    = 1'b1;
                mem_wdata = ctl_q;
                mem_wdata[CW_OWNER] = 1'b0;
            end
            default: mem_req = 1'b0;
        endcase
    end

    assign tx_req = (state == S_XMIT);
    assign tx_buf = buf_q;
    assign tx_len = (len_q[LW-1:0] > CAP) ? CAP : len_q[LW-1:0];
    assign tx_pad = ctl_q[CW_PAD];
    assign tx_crc = ctl_q[CW_CRC];

    assign ev_berr    = mem_req && mem_gnt && mem_err;
    assign ev_unavail = (state == S_RD_CTL) && acc_ok && !mem_rdata[CW_OWNER];
    assign ev_done    = (state == S_WB_CTL) && acc_ok && ctl_q[CW_IRQ];
    assign cur_addr   = cur_q;
    assign buf_addr   = buf_q;

    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_gnt |=> mem_req && $stable(mem_addr)); // R3
    AST_UNAVAIL_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        ev_unavail |=> !mem_req && !tx_req); // R6
    AST_BERR_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        ev_berr |=> !mem_req && !tx_req); // R7
endmodule

// File: rtl/tx_ring_walker.sv
// Top of the transmit descriptor ring walker: joins the register file and
// the walk sequencer. Assumes a single-word memory port whose read data and
// error flag arrive with the grant.
module tx_ring_walker
    import tx_ring_pkg::*;
#(
    parameter int DW      = 32,
    parameter int RW      = 8,
    parameter int LW      = 16,
    parameter int LEN_MAX = 1514
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [RW-1:0] cfg_addr,
    input  logic [DW-1:0] cfg_wdata,
    output logic [DW-1:0] cfg_rdata,
    output logic          mem_req,
    output logic          mem_we,
    output logic [DW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic          mem_gnt,
    input  logic [DW-1:0] mem_rdata,
    input  logic          mem_err,
    output logic          tx_req,
    output logic [DW-1:0] tx_buf,
    output logic [LW-1:0] tx_len,
    output logic          tx_pad,
    output logic          tx_crc,
    input  logic          tx_done,
    input  logic          tx_ok,
    output logic          irq
);
    logic          start_pulse, base_load, ev_done, ev_unavail, ev_berr;
    logic [DW-1:0] base_val, cur_addr, buf_addr;

    tx_ring_regs #(.DW(DW), .RW(RW)) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .ev_done(ev_done),
        .ev_unavail(ev_unavail), .ev_berr(ev_berr), .cur_addr(cur_addr),
        .buf_addr(buf_addr), .start_pulse(start_pulse), .base_load(base_load),
        .base_val(base_val), .irq(irq)
    );

    tx_ring_seq #(.DW(DW), .LW(LW), .LEN_MAX(LEN_MAX)) u_seq (
        .clk(clk), .rst_n(rst_n), .start_pulse(start_pulse),
        .base_load(base_load), .base_val(base_val), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_gnt(mem_gnt), .mem_rdata(mem_rdata), .mem_err(mem_err),
        .tx_req(tx_req), .tx_buf(tx_buf), .tx_len(tx_len), .tx_pad(tx_pad),
        .tx_crc(tx_crc), .tx_done(tx_done), .tx_ok(tx_ok), .ev_done(ev_done),
        .ev_unavail(ev_unavail), .ev_berr(ev_berr), .cur_addr(cur_addr),
        .buf_addr(buf_addr)
    );

    AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        tx_req && !tx_done |=> tx_req && $stable(tx_buf) && $stable(tx_len)); // R4
    AST_LEN_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        tx_req |-> tx_len <= LW'(LEN_MAX)); // R4
    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_req && mem_req)); // R5
endmodule

// File: tb/tx_ring_walker_bench.sv
module tx_ring_walker_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_addr = 8'h00;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        mem_req, mem_we, mem_gnt, mem_err;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        tx_req, tx_pad, tx_crc, irq;
    logic [31:0] tx_buf;
    logic [15:0] tx_len;
    logic        tx_done = 1'b0, tx_ok = 1'b0;

    logic [31:0] mem [0:63];
    logic        gnt_phase = 1'b0;
    logic        err_en = 1'b0;
    logic [31:0] err_addr = '0;
    int checks = 0, failures = 0, tx_seen = 0;

    typedef struct packed { logic [31:0] buf_a; logic [15:0] len; logic pad; logic crc; logic ok; } item_t;
    item_t exp_q[$];

    always #4 clk = ~clk;

    tx_ring_walker u_tx_ring_walker (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_gnt(mem_gnt), .mem_rdata(mem_rdata), .mem_err(mem_err),
        .tx_req(tx_req), .tx_buf(tx_buf), .tx_len(tx_len), .tx_pad(tx_pad),
        .tx_crc(tx_crc), .tx_done(tx_done), .tx_ok(tx_ok), .irq(irq)
    );

    // Memory model: grant every other cycle, data and error with grant.
    assign mem_gnt   = mem_req && gnt_phase;
    assign mem_rdata = mem[mem_addr[7:2]];
    assign mem_err   = mem_gnt && err_en && (mem_addr == err_addr);
    always @(posedge clk) begin
        gnt_phase <= ~gnt_phase;
        if (mem_gnt && mem_we && !mem_err) mem[mem_addr[7:2]] <= mem_wdata;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk); cfg_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk); cfg_addr = a; #1 d = cfg_rdata;
    endtask

    task automatic push(input logic [31:0] b, input logic [15:0] l, input logic p, input logic c, input logic ok);
        item_t it;
        it.buf_a = b; it.len = l; it.pad = p; it.crc = c; it.ok = ok;
        exp_q.push_back(it);
    endtask

    task automatic wait_stat(input int bitn);
        logic [31:0] v;
        for (int i = 0; i < 400; i++) begin
            rd(8'hB0, v);
            if (v[bitn]) return;
        end
    endtask

    // Monitor: pop expected transfer and compare, then answer with done.
    initial begin
        item_t it;
        forever begin
            @(negedge clk);
            if (tx_req) begin
                tx_seen++;
                if (exp_q.size() == 0) begin
                    checks++; failures++;
                    $display("FAIL R4 actual=unexpected tx_req buf=%h expected=none", tx_buf);
                    it = '0;
                end else begin
                    it = exp_q.pop_front();
                    check("R4 buf", tx_buf, it.buf_a);
                    check("R4 len", {16'h0, tx_len}, {16'h0, it.len});
                    check("R4 pad/crc", {30'h0, tx_pad, tx_crc}, {30'h0, it.pad, it.crc});
                end
                repeat (3) @(negedge clk);
                tx_done = 1'b1; tx_ok = it.ok;
                @(negedge clk);
                tx_done = 1'b0; tx_ok = 1'b0;
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (50000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] v;
        for (int i = 0; i < 64; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 mem_req/tx_req/irq", {29'h0, mem_req, tx_req, irq}, 32'h0);
        rd(8'hB0, v); check("R1 status", v, 32'h0);
        rd(8'hCC, v); check("R1 cur", v, 32'h0);

        // R2 base load
        wr(8'h88, 32'h40);
        rd(8'h88, v); check("R2 base", v, 32'h40);
        rd(8'hCC, v); check("R2 cur", v, 32'h40);
        wr(8'h88, 32'h00);
        rd(8'hCC, v); check("R2 cur reload", v, 32'h00);

        // Ring: desc0 @0x00, desc1 @0x10, desc2 @0x20 (software owned)
        mem[0] = 32'h8000_0007; mem[1] = 32'h1000; mem[2] = 32'd2000; mem[3] = 32'h10;
        mem[4] = 32'h8000_0002; mem[5] = 32'h2000; mem[6] = 32'd60;   mem[7] = 32'h20;
        mem[8] = 32'h0000_0000; mem[9] = 32'h0;    mem[10] = 32'h0;   mem[11] = 32'h0;
        wr(8'hAC, 32'h01FC_0000);
        push(32'h1000, 16'd1514, 1'b1, 1'b1, 1'b1);  // R4 truncation
        push(32'h2000, 16'd60, 1'b0, 1'b1, 1'b0);
        wr(8'hA0, 32'h1);                            // R3 start
        wait_stat(23);
        check("R4 both frames sent", tx_seen, 32'd2);
        check("R5 len word ok", mem[2], 32'h0008_07D0);
        check("R5 ctl word desc0", mem[0], 32'h0000_0007);
        check("R5 len word fail", mem[6], 32'h0000_003C);
        check("R5 ctl word desc1", mem[4], 32'h0000_0002);
        rd(8'hB0, v); check("R6 R8 status", v, 32'h0084_0000);
        rd(8'hCC, v); check("R6 cur stays on unowned", v, 32'h20);
        rd(8'hD0, v); check("R12 buf", v, 32'h2000);
        check("R10 irq high", {31'h0, irq}, 32'h1);

        // R9 write one to clear
        wr(8'hB0, 32'h0080_0000);
        rd(8'hB0, v); check("R9 w1c", v, 32'h0004_0000);
        // R10 masking
        wr(8'hAC, 32'h0080_0000);
        @(negedge clk); check("R10 irq masked", {31'h0, irq}, 32'h0);
        wr(8'hB0, 32'hFFFF_FFFF);
        rd(8'hB0, v); check("R9 clear all", v, 32'h0);

        // R8 descriptor without completion interrupt
        mem[8] = 32'h8000_0000; mem[9] = 32'h3000; mem[10] = 32'd100; mem[11] = 32'h00;
        push(32'h3000, 16'd100, 1'b0, 1'b0, 1'b1);
        wr(8'hA0, 32'h1);
        wait_stat(23);
        rd(8'hB0, v); check("R8 no done bit", v, 32'h0080_0000);
        check("R5 len word desc2", mem[10], 32'h0008_0064);
        rd(8'hCC, v); check("R5 follows link", v, 32'h00);
        check("R10 irq unavailable", {31'h0, irq}, 32'h1);
        wr(8'hB0, 32'hFFFF_FFFF);

        // R11 start with bit0 clear
        mem[0] = 32'h8000_0001;
        wr(8'hA0, 32'h2);
        v = 0;
        for (int i = 0; i < 10; i++) begin @(negedge clk); if (mem_req) v = 1; end
        check("R11 no fetch", v, 32'h0);

        // R7 bus error on buffer fetch
        err_en = 1'b1; err_addr = 32'h04;
        wr(8'hA0, 32'h1);
        wait_stat(24);
        repeat (10) @(negedge clk);
        rd(8'hB0, v); check("R7 status", v, 32'h0100_0000);
        check("R7 no transfer", tx_seen, 32'd3);
        rd(8'hCC, v); check("R7 cur held", v, 32'h00);
        check("R7 mem_req low", {31'h0, mem_req}, 32'h0);
        err_en = 1'b0;

        check("R4 queue drained", exp_q.size(), 32'd0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule